// File: doc/BRIEF.md
# Tagged Branch Target Buffer with Return Stack

This block sits in the fetch stage of a processor and answers each fetch address in the same cycle with three things. It says whether it recognises the address as a branch, whether the branch is predicted taken, and which address to fetch next if it is. The buffer is a direct-mapped table indexed by the low word-address bits of the fetch PC. Every entry stores the complete branch address, so a lookup that lands on an entry belonging to a different branch reports a miss and never supplies a foreign target. Each entry also holds a saturating direction counter and the last taken target.

Resolved branches come back from later pipeline stages on a correction port with their address, outcome and target. A correction that hits trains the counter, and a taken correction also refreshes the target. A taken branch that misses claims the indexed entry, overwriting whatever was there. A not-taken branch that misses is dropped.

Returns are predicted from a small return-address stack. A call pushes its own address plus one instruction width. A fetch flagged as a return pops the stack and uses the popped value as a taken target. When the stack is empty, the return is looked up in the buffer like any other address. The stack wraps when it is full, so the oldest return address is lost.

Top module: `tagged_btb`

## Requirements
- R1: After reset every entry is invalid and the stack is empty, so every lookup reports hit 0, taken 0 and target 0.
- R2: A buffer hit requires a valid entry at the index whose stored address equals the whole fetch PC. On a miss, hit, taken and target are all 0.
- R3: The index is fetch PC bits [IDX_W+1:2]. Two addresses that share these bits but differ elsewhere never hit each other's entry.
- R4: A taken correction that misses overwrites the indexed entry with the new address and target, and sets its counter to the weakly-taken value 2. A later lookup of that address is then predicted taken to that target.
- R5: A not-taken correction that misses changes no entry: a later lookup of that address still misses, and the entry at that index keeps its previous owner.
- R6: A correction that hits moves the 2-bit counter up by one on taken and down by one on not-taken, saturating at 0 and 3. The prediction is taken when the counter is 2 or 3. A hit with a counter of 0 or 1 still reports hit 1 and the stored target. Only a taken correction replaces the stored target.
- R7: When a lookup and a correction address the same entry in the same cycle, the lookup reports the contents from before the correction. The update becomes visible from the next cycle.
- R8: A push stores call address + 4. A return fetch with a non-empty stack reports hit 1, taken 1, stack flag 1 and the top value as target, then removes that value.
- R9: A return fetch with an empty stack reports the buffer lookup for its PC with stack flag 0, and it leaves the stack empty.
- R10: The stack holds 8 values. A push onto a full stack overwrites the oldest value. After nine pushes, eight pops return the last eight values newest first, and the ninth pop finds the stack empty.
- R11: A push and a return pop in the same cycle on a non-empty stack predict the old top. The old top is then replaced with the new call address + 4, and the depth is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_pc | input | AW | Address being fetched this cycle |
| fetch_ret | input | 1 | Fetched instruction is a return; pops the stack |
| call_push | input | 1 | A call is being fetched; push call_pc + 4 |
| call_pc | input | AW | Address of the call instruction |
| fix_valid | input | 1 | Correction from a resolved branch is present |
| fix_pc | input | AW | Address of the resolved branch |
| fix_taken | input | 1 | Actual outcome, 1 = taken |
| fix_target | input | AW | Actual target of the resolved branch |
| pred_hit | output | 1 | Fetch address recognised (buffer hit or stack use) |
| pred_taken | output | 1 | Predicted taken |
| pred_target | output | AW | Predicted target, 0 when pred_hit is 0 |
| pred_from_ras | output | 1 | Target came from the return stack |

## Verification
All prediction outputs are combinational from registered state, so a wrong entry, counter or stack pointer shows up on the ports in the first cycle that address or return is fetched after the faulty update. A lost or spurious allocation therefore appears as a wrong hit bit on the very next lookup of that PC or of an alias sharing its index. A counter off by one appears only at the 1-to-2 threshold, so the bench walks counters across that boundary in both directions. A stack pointer error appears as a wrong return target or a wrong empty fallback, which the overflow and simultaneous push-pop sequences expose within a few cycles.

// File: rtl/btb_pkg.sv
package btb_pkg;
   // Instruction width in bytes; sets the index shift and the return offset.
   localparam int unsigned BTB_INSN_BYTES = 4;
   localparam int unsigned BTB_ALIGN_BITS = $clog2(BTB_INSN_BYTES);
   localparam int unsigned BTB_CTR_MAX_W  = 8;

   // Saturating step of a direction counter of cw bits.
   function automatic logic [BTB_CTR_MAX_W-1:0] ctr_next(
      input logic [BTB_CTR_MAX_W-1:0] c,
      input logic                     up,
      input int unsigned              cw);
      logic [BTB_CTR_MAX_W-1:0] top;
      top = BTB_CTR_MAX_W'((1 << cw) - 1);
      if (up) return (c == top) ? c : c + 1'b1;
      else    return (c == '0)  ? c : c - 1'b1;
   endfunction
endpackage

// File: rtl/btb_table.sv
module btb_table
   import btb_pkg::*;
#(
   parameter int unsigned AW    = 32,
   parameter int unsigned IDX_W = 4,
   parameter int unsigned CW    = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [AW-1:0]            rd_pc,
   output logic                     rd_hit,
   output logic                     rd_taken,
   output logic [AW-1:0]            rd_tgt,
   input  logic                     wr_en,
   input  logic [AW-1:0]            wr_pc,
   input  logic                     wr_taken,
   input  logic [AW-1:0]            wr_tgt,
   output logic                     wr_hit,
   output logic [(1<<IDX_W)-1:0]    valid_vec
);
   localparam int unsigned ENTRIES = 1 << IDX_W;
   localparam int unsigned SH      = BTB_ALIGN_BITS;
   localparam logic [CW-1:0] CTR_INIT = CW'(1 << (CW-1));

   initial begin
      assert (CW >= 1 && CW <= BTB_CTR_MAX_W) else $fatal(1, "btb_table: CW out of range");
      assert (IDX_W + SH < AW) else $fatal(1, "btb_table: index wider than address");
   end

   logic [ENTRIES-1:0] valid_q;
   logic [AW-1:0]      pc_q  [ENTRIES];
   logic [AW-1:0]      tgt_q [ENTRIES];
   logic [CW-1:0]      ctr_q [ENTRIES];

   logic [IDX_W-1:0]   ri, wi;
   logic [BTB_CTR_MAX_W-1:0] step_w;

   assign ri = rd_pc[IDX_W+SH-1:SH];
   assign wi = wr_pc[IDX_W+SH-1:SH];

   // Lookup path: full-address compare, reads pre-update contents.
   always_comb begin
      rd_hit   = valid_q[ri] && (pc_q[ri] == rd_pc);
      rd_taken = rd_hit && ctr_q[ri][CW-1];
      rd_tgt   = rd_hit ? tgt_q[ri] : '0;
   end

   assign wr_hit    = valid_q[wi] && (pc_q[wi] == wr_pc);
   assign step_w    = ctr_next(BTB_CTR_MAX_W'(ctr_q[wi]), wr_taken, CW);
   assign valid_vec = valid_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
      end else if (wr_en) begin
         if (wr_hit) begin
            ctr_q[wi] <= step_w[CW-1:0];
            if (wr_taken) tgt_q[wi] <= wr_tgt;
         end else if (wr_taken) begin
            valid_q[wi] <= 1'b1;
            pc_q[wi]    <= wr_pc;
            tgt_q[wi]   <= wr_tgt;
            ctr_q[wi]   <= CTR_INIT;
         end
      end
   end
endmodule

// File: rtl/btb_ras.sv
module btb_ras #(
   parameter int unsigned AW    = 32,
   parameter int unsigned DEPTH = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       push,
   input  logic [AW-1:0]              push_val,
   input  logic                       pop,
   output logic                       nonempty,
   output logic [AW-1:0]              top_val,
   output logic [$clog2(DEPTH):0]     depth
);
   localparam int unsigned PW = $clog2(DEPTH);
   localparam logic [PW:0] FULL = (PW+1)'(DEPTH);

   initial begin
      assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0)
         else $fatal(1, "btb_ras: DEPTH must be a power of two");
   end

   logic [PW-1:0] ptr_q;
   logic [PW:0]   cnt_q;
   logic [PW-1:0] top_idx;
   logic          pop_eff;
   logic [AW-1:0] slot_q [DEPTH];

   assign top_idx  = ptr_q - 1'b1;
   assign nonempty = (cnt_q != '0);
   assign pop_eff  = pop && nonempty;
   assign top_val  = slot_q[top_idx];
   assign depth    = cnt_q;

   // One register per slot; write index chosen by the pointer.
   for (genvar s = 0; s < DEPTH; s++) begin : g_slot
      logic wr_here;
      assign wr_here = push && (pop_eff ? (top_idx == PW'(s)) : (ptr_q == PW'(s)));
      always_ff @(posedge clk) begin
         if (wr_here) slot_q[s] <= push_val;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
         cnt_q <= '0;
      end else if (push && !pop_eff) begin
         ptr_q <= ptr_q + 1'b1;
         if (cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
      end else if (pop_eff && !push) begin
         ptr_q <= ptr_q - 1'b1;
         cnt_q <= cnt_q - 1'b1;
      end
   end
endmodule

// File: rtl/tagged_btb.sv
module tagged_btb
   import btb_pkg::*;
#(
   parameter int unsigned AW        = 32,
   parameter int unsigned IDX_W     = 4,
   parameter int unsigned CW        = 2,
   parameter int unsigned RAS_DEPTH = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] fetch_pc,
   input  logic          fetch_ret,
   input  logic          call_push,
   input  logic [AW-1:0] call_pc,
   input  logic          fix_valid,
   input  logic [AW-1:0] fix_pc,
   input  logic          fix_taken,
   input  logic [AW-1:0] fix_target,
   output logic          pred_hit,
   output logic          pred_taken,
   output logic [AW-1:0] pred_target,
   output logic          pred_from_ras
);
   localparam int unsigned ENTRIES = 1 << IDX_W;
   localparam int unsigned RDW     = $clog2(RAS_DEPTH) + 1;

   logic               tbl_hit, tbl_taken, tbl_wr_hit;
   logic [AW-1:0]      tbl_tgt;
   logic [ENTRIES-1:0] tbl_valid;
   logic               ras_ne;
   logic [AW-1:0]      ras_top;
   logic [RDW-1:0]     ras_cnt;
   logic               use_ras;

   btb_table #(.AW(AW), .IDX_W(IDX_W), .CW(CW)) u_table (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_pc     (fetch_pc),
      .rd_hit    (tbl_hit),
      .rd_taken  (tbl_taken),
      .rd_tgt    (tbl_tgt),
      .wr_en     (fix_valid),
      .wr_pc     (fix_pc),
      .wr_taken  (fix_taken),
      .wr_tgt    (fix_target),
      .wr_hit    (tbl_wr_hit),
      .valid_vec (tbl_valid)
   );

   btb_ras #(.AW(AW), .DEPTH(RAS_DEPTH)) u_ras (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (call_push),
      .push_val (call_pc + AW'(BTB_INSN_BYTES)),
      .pop      (fetch_ret),
      .nonempty (ras_ne),
      .top_val  (ras_top),
      .depth    (ras_cnt)
   );

   assign use_ras = fetch_ret && ras_ne;

   always_comb begin
      pred_from_ras = use_ras;
      if (use_ras) begin
         pred_hit    = 1'b1;
         pred_taken  = 1'b1;
         pred_target = ras_top;
      end else begin
         pred_hit    = tbl_hit;
         pred_taken  = tbl_taken;
         pred_target = tbl_tgt;
      end
   end
endmodule

// File: rtl/tagged_btb_chk.sv
module tagged_btb_chk #(
   parameter int unsigned AW        = 32,
   parameter int unsigned ENTRIES   = 16,
   parameter int unsigned RAS_DEPTH = 8,
   parameter int unsigned DW        = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               fetch_ret,
   input logic               call_push,
   input logic               fix_valid,
   input logic               fix_taken,
   input logic               fix_hit,
   input logic [ENTRIES-1:0] valid_vec,
   input logic [DW-1:0]      ras_depth,
   input logic               pred_hit,
   input logic               pred_taken,
   input logic [AW-1:0]      pred_target,
   input logic               pred_from_ras
);
   AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (valid_vec == '0) && (ras_depth == '0)); // R1
   AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !pred_hit |-> !pred_taken && (pred_target == '0)); // R2
   AST_TAKEN_MISS_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
      (fix_valid && fix_taken && !fix_hit) |=> (valid_vec != '0)); // R4
   AST_NT_MISS_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (fix_valid && !fix_taken && !fix_hit) |=> $stable(valid_vec)); // R5
   AST_STACK_NEEDS_RET: assert property (@(posedge clk) disable iff (!rst_n)
      pred_from_ras |-> fetch_ret && pred_hit && pred_taken); // R8
   AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      ras_depth <= DW'(RAS_DEPTH)); // R10
   AST_SWAP_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
      (call_push && fetch_ret && ras_depth != '0) |=> $stable(ras_depth)); // R11
endmodule

bind tagged_btb tagged_btb_chk #(
   .AW(AW), .ENTRIES(ENTRIES), .RAS_DEPTH(RAS_DEPTH), .DW(RDW)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .fetch_ret     (fetch_ret),
   .call_push     (call_push),
   .fix_valid     (fix_valid),
   .fix_taken     (fix_taken),
   .fix_hit       (tbl_wr_hit),
   .valid_vec     (tbl_valid),
   .ras_depth     (ras_cnt),
   .pred_hit      (pred_hit),
   .pred_taken    (pred_taken),
   .pred_target   (pred_target),
   .pred_from_ras (pred_from_ras)
);

// File: tb/tagged_btb_test.sv
`timescale 1ns/1ps
module tagged_btb_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] fetch_pc = '0;
   logic        fetch_ret = 1'b0;
   logic        call_push = 1'b0;
   logic [31:0] call_pc = '0;
   logic        fix_valid = 1'b0;
   logic [31:0] fix_pc = '0;
   logic        fix_taken = 1'b0;
   logic [31:0] fix_target = '0;
   logic        pred_hit, pred_taken, pred_from_ras;
   logic [31:0] pred_target;

   int n_cmp = 0;
   int n_bad = 0;

   // Reference state built from the requirements
   bit          m_v   [16];
   logic [31:0] m_pc  [16];
   logic [31:0] m_tg  [16];
   int          m_ct  [16];
   logic [31:0] m_st  [8];
   int          m_sp = 0;
   int          m_cnt = 0;

   always #4 clk = ~clk;

   tagged_btb uut (
      .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .fetch_ret(fetch_ret),
      .call_push(call_push), .call_pc(call_pc), .fix_valid(fix_valid),
      .fix_pc(fix_pc), .fix_taken(fix_taken), .fix_target(fix_target),
      .pred_hit(pred_hit), .pred_taken(pred_taken), .pred_target(pred_target),
      .pred_from_ras(pred_from_ras)
   );

   function automatic int idx_of(logic [31:0] pc);
      return int'(pc[5:2]);
   endfunction

   task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // One cycle: drive, compare combinational prediction, clock, update model.
   task automatic step(string tag, logic [31:0] pc, logic ret, logic push, logic [31:0] cpc,
                       logic fv, logic [31:0] fpc, logic ft, logic [31:0] ftg);
      logic        eh, et, er;
      logic [31:0] eg;
      int          i, w;
      @(negedge clk);
      fetch_pc = pc; fetch_ret = ret; call_push = push; call_pc = cpc;
      fix_valid = fv; fix_pc = fpc; fix_taken = ft; fix_target = ftg;
      #1;
      i = idx_of(pc);
      if (ret && m_cnt > 0) begin
         eh = 1; et = 1; er = 1; eg = m_st[(m_sp + 7) % 8];
      end else if (m_v[i] && m_pc[i] == pc) begin
         eh = 1; et = (m_ct[i] >= 2); er = 0; eg = m_tg[i];
      end else begin
         eh = 0; et = 0; er = 0; eg = '0;
      end
      chk(tag, "hit", 32'(pred_hit), 32'(eh));
      chk(tag, "taken", 32'(pred_taken), 32'(et));
      chk(tag, "target", pred_target, eg);
      chk(tag, "from_stack", 32'(pred_from_ras), 32'(er));
      @(posedge clk);
      // correction
      if (fv) begin
         w = idx_of(fpc);
         if (m_v[w] && m_pc[w] == fpc) begin
            if (ft) begin
               if (m_ct[w] < 3) m_ct[w]++;
               m_tg[w] = ftg;
            end else if (m_ct[w] > 0) m_ct[w]--;
         end else if (ft) begin
            m_v[w] = 1; m_pc[w] = fpc; m_tg[w] = ftg; m_ct[w] = 2;
         end
      end
      // stack
      if (push && ret && m_cnt > 0) begin
         m_st[(m_sp + 7) % 8] = cpc + 4;
      end else if (push) begin
         m_st[m_sp] = cpc + 4;
         m_sp = (m_sp + 1) % 8;
         if (m_cnt < 8) m_cnt++;
      end else if (ret && m_cnt > 0) begin
         m_sp = (m_sp + 7) % 8;
         m_cnt--;
      end
   endtask

   task automatic look(string tag, logic [31:0] pc);
      step(tag, pc, 0, 0, 0, 0, 0, 0, 0);
   endtask

   task automatic fix(string tag, logic [31:0] pc, logic t, logic [31:0] tg);
      step(tag, 32'h0, 0, 0, 0, 1, pc, t, tg);
   endtask

   initial begin : watchdog
      #(8 * 150000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : main
      logic [31:0] bases [3];
      void'($urandom(32'd20240611));
      bases[0] = 32'h1000; bases[1] = 32'h2000; bases[2] = 32'h3000;
      for (int k = 0; k < 16; k++) begin m_v[k] = 0; m_ct[k] = 0; m_pc[k] = '0; m_tg[k] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      look("R1", 32'h1000);
      look("R1", 32'h0);
      step("R1", 32'h1004, 1, 0, 0, 0, 0, 0, 0);
      // R5: not-taken miss does not allocate
      fix("R5", 32'h1010, 0, 32'h9000);
      look("R5", 32'h1010);
      // R4: taken miss allocates weakly taken
      fix("R4", 32'h1010, 1, 32'h4000);
      look("R4", 32'h1010);
      // R3: alias with same index misses
      look("R3", 32'h2010);
      fix("R5", 32'h2010, 0, 32'h7777);
      look("R5", 32'h1010);
      fix("R4", 32'h2010, 1, 32'h5000);
      look("R3", 32'h1010);
      look("R4", 32'h2010);
      // R6: counter walk across threshold
      fix("R6", 32'h2010, 0, 32'h6666);
      look("R6", 32'h2010);
      fix("R6", 32'h2010, 0, 32'h6666);
      fix("R6", 32'h2010, 0, 32'h6666);
      look("R6", 32'h2010);
      fix("R6", 32'h2010, 1, 32'h6000);
      fix("R6", 32'h2010, 1, 32'h6000);
      look("R6", 32'h2010);
      fix("R6", 32'h2010, 1, 32'h6100);
      fix("R6", 32'h2010, 1, 32'h6200);
      fix("R6", 32'h2010, 0, 32'h0);
      look("R6", 32'h2010);
      // R7: simultaneous lookup and correction on same entry
      step("R7", 32'h3020, 0, 0, 0, 1, 32'h3020, 1, 32'h8000);
      look("R7", 32'h3020);
      // R9: return with empty stack uses the table
      step("R9", 32'h2010, 1, 0, 0, 0, 0, 0, 0);
      step("R9", 32'h1234, 1, 0, 0, 0, 0, 0, 0);
      // R8: push then pop
      step("R8", 32'h0, 0, 1, 32'h100, 0, 0, 0, 0);
      step("R8", 32'h2010, 1, 0, 0, 0, 0, 0, 0);
      step("R9", 32'h2010, 1, 0, 0, 0, 0, 0, 0);
      // R10: overflow wraps
      for (int k = 0; k < 9; k++)
         step("R10", 32'h0, 0, 1, 32'h200 + 32'(k) * 16, 0, 0, 0, 0);
      for (int k = 0; k < 9; k++)
         step("R10", 32'h3020, 1, 0, 0, 0, 0, 0, 0);
      // R11: push and pop in one cycle
      step("R11", 32'h0, 0, 1, 32'h700, 0, 0, 0, 0);
      step("R11", 32'h0, 1, 1, 32'h800, 0, 0, 0, 0);
      step("R11", 32'h0, 1, 0, 0, 0, 0, 0, 0);
      step("R11", 32'h0, 1, 0, 0, 0, 0, 0, 0);

      // Constrained random mix
      for (int n = 0; n < 4000; n++) begin
         logic [31:0] lp, fp, cp, tg;
         logic r, p, fv, ft;
         lp = bases[$urandom_range(0, 2)] + 32'($urandom_range(0, 15)) * 4;
         fp = bases[$urandom_range(0, 2)] + 32'($urandom_range(0, 15)) * 4;
         cp = 32'($urandom_range(0, 255)) * 4 + 32'h8000;
         tg = 32'($urandom_range(0, 4095)) * 4 + 32'h10000;
         r  = ($urandom_range(0, 7) == 0);
         p  = ($urandom_range(0, 7) == 0);
         fv = ($urandom_range(0, 2) != 0);
         ft = ($urandom_range(0, 1) == 1);
         if (r && m_cnt > 0) step("R8", lp, r, p, cp, fv, fp, ft, tg);
         else                step("R2", lp, r, p, cp, fv, fp, ft, tg);
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule